// File: doc/BRIEF.md
# Audio Ring Buffer Pointer and Watermark Tracker

This block keeps the bookkeeping for one circular byte buffer that an audio DMA engine reads from (playback) or writes into (capture). Software sets the buffer window with a start address and an inclusive last address. It also sets a watermark and may overwrite either pointer at any time. The data mover reports progress with an advance strobe and a byte count. In playback the count moves the read pointer. In capture it moves the write pointer. Each pointer is one bit wider than the byte address. The top bit is a lap toggle, so a full buffer and an empty buffer can be told apart without a separate counter.

From the two pointers the block derives the number of bytes held, the empty and full states, and the byte offset of the active pointer from the buffer start. An advance that would run past the other pointer is cut short. An advance that arrives when there is nothing at all to move raises a one-cycle underflow flag (playback) or overflow flag (capture).

A small state machine drives the watermark event. It has two states. In `WAIT_REARM` the event is silent; this is the reset state, and the machine leaves it through the transition `rearm` taken on the re-arm pulse. In `ARMED` the event output is high whenever the level test is true. The machine then takes the transition `fire`, back to `WAIT_REARM`, so the event lasts exactly one cycle. The level test depends on the mode. In playback the free space must be strictly greater than the mark. In capture the held byte count must be strictly greater than the mark.

Top module: `rbuf_tracker`

## Requirements
- R1: After reset both pointers, base, end and mark are zero. The buffer reads empty and not full. The watermark machine sits in `WAIT_REARM`, so `mark_evt` stays low until a re-arm, even though the test would be true.
- R2: The top pointer bit (bit 31 at default width) is the lap toggle and the lower bits are the byte address. `buf_empty` is high when the two pointers are identical. `buf_full` is high when the addresses match and the lap bits differ. The two are never high together.
- R3: `fill_level` equals the write address minus the read address when the lap bits match. When they differ it equals that difference plus the buffer size, where size = end - base + 1. A full buffer reports the full size.
- R4: An accepted advance moves only the read pointer in playback mode (`capture_mode`=0) and only the write pointer in capture mode (`capture_mode`=1). A pointer that passes the inclusive end address continues from the base and inverts its lap bit.
- R5: The advance is clamped to the held bytes (playback) or the free bytes (capture), so a pointer never overtakes the other one. A clamped advance raises no error flag.
- R6: In playback, an advance strobe while the buffer is empty raises `underflow` for one cycle, registered one cycle after the strobe, and leaves the read pointer unchanged.
- R7: In capture, an advance strobe while the buffer is full raises `overflow` for one cycle, registered one cycle after the strobe, and leaves the write pointer unchanged.
- R8: In playback the event test is free space (size minus level) strictly greater than the mark. Equality does not fire.
- R9: In capture the event test is level strictly greater than the mark. Equality does not fire.
- R10: `mark_evt` is high for a single cycle per firing. It stays low afterwards, even while the test remains true, until `rearm` is pulsed. After that it fires again if the test holds.
- R11: A software pointer write takes effect on the next clock. It wins over an advance to the same pointer in the same cycle.
- R12: `cur_offset` equals the active pointer's address (read in playback, write in capture) minus the base address, with the lap bit ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_mode | input | 1 | 0 = playback (advance moves read pointer), 1 = capture (advance moves write pointer) |
| base_we | input | 1 | Load the buffer start address |
| base_wdata | input | ADDR_W | Buffer start address |
| end_we | input | 1 | Load the inclusive last address |
| end_wdata | input | ADDR_W | Inclusive last address |
| mark_we | input | 1 | Load the watermark |
| mark_wdata | input | ADDR_W | Watermark in bytes |
| rdp_we | input | 1 | Software write of the read pointer |
| rdp_wdata | input | ADDR_W+1 | Read pointer value, lap bit on top |
| wrp_we | input | 1 | Software write of the write pointer |
| wrp_wdata | input | ADDR_W+1 | Write pointer value, lap bit on top |
| rearm | input | 1 | Re-arm pulse for the watermark event |
| adv_valid | input | 1 | Advance strobe from the data mover |
| adv_bytes | input | STEP_W | Bytes moved by this advance |
| rd_ptr | output | ADDR_W+1 | Current read pointer |
| wr_ptr | output | ADDR_W+1 | Current write pointer |
| fill_level | output | ADDR_W+1 | Bytes held in the buffer |
| buf_empty | output | 1 | Buffer empty |
| buf_full | output | 1 | Buffer full |
| cur_offset | output | ADDR_W | Active pointer address minus base |
| underflow | output | 1 | Playback consume attempt on an empty buffer |
| overflow | output | 1 | Capture produce attempt on a full buffer |
| mark_evt | output | 1 | One-shot watermark event |

## Verification
Some properties are checked on every cycle. Empty and full never assert together. The held byte count never exceeds the buffer size. The event never lasts two cycles. An error flag appears only after a strobe on an empty (playback) or full (capture) buffer. The pointer on the idle side stays put unless software writes it.

Other behaviour needs the directed scenarios. These cover the exact arithmetic of level and offset across a lap, the wrap from the end address back to the base with the lap bit flipped, and the clamp amount. They also cover the strict-inequality boundary of the watermark in both modes, re-arm refiring while the test is still true, and software writes winning over a same-cycle advance.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    typedef enum logic {
        MK_WAIT_REARM = 1'b0,
        MK_ARMED      = 1'b1
    } mark_state_e;

endpackage

// File: rtl/rbuf_level.sv
module rbuf_level #(
    parameter int ADDR_W = 31
) (
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] end_a,
    input  logic [ADDR_W:0]   rd_p,
    input  logic [ADDR_W:0]   wr_p,
    output logic [ADDR_W:0]   size,
    output logic [ADDR_W:0]   level,
    output logic [ADDR_W:0]   free_sp,
    output logic              empty,
    output logic              full
);
    localparam int LVL_W = ADDR_W + 1;

    logic              lap_diff;
    logic              addr_eq;
    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] adj;

    always_comb begin
        size     = {1'b0, end_a} - {1'b0, base_a} + LVL_W'(1);
        lap_diff = rd_p[ADDR_W] ^ wr_p[ADDR_W];
        addr_eq  = (rd_p[ADDR_W-1:0] == wr_p[ADDR_W-1:0]);
        empty    = addr_eq && !lap_diff;
        full     = addr_eq && lap_diff;
        diff     = wr_p[ADDR_W-1:0] - rd_p[ADDR_W-1:0];
        adj      = lap_diff ? (diff + size[ADDR_W-1:0]) : diff;
        level    = full ? size : {1'b0, adj};
        free_sp  = size - level;
    end

endmodule

// File: rtl/rbuf_step.sv
module rbuf_step #(
    parameter int ADDR_W = 31
) (
    input  logic [ADDR_W:0]   ptr,
    input  logic [ADDR_W:0]   step,
    input  logic [ADDR_W-1:0] end_a,
    input  logic [ADDR_W:0]   size,
    output logic [ADDR_W:0]   nxt
);
    logic [ADDR_W:0] sum;
    logic [ADDR_W:0] wrapped;

    always_comb begin
        sum     = {1'b0, ptr[ADDR_W-1:0]} + step;
        wrapped = sum - size;
        if (sum > {1'b0, end_a}) begin
            nxt = {~ptr[ADDR_W], wrapped[ADDR_W-1:0]};
        end else begin
            nxt = {ptr[ADDR_W], sum[ADDR_W-1:0]};
        end
    end

endmodule

// File: rtl/rbuf_mark_fsm.sv
module rbuf_mark_fsm
    import rbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic cond,
    output logic fire
);
    mark_state_e state_q;
    mark_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MK_WAIT_REARM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MK_WAIT_REARM: if (rearm) state_d = MK_ARMED;
            MK_ARMED:      if (cond)  state_d = MK_WAIT_REARM;
            default:       state_d = MK_WAIT_REARM;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            MK_WAIT_REARM: fire = 1'b0;
            MK_ARMED:      fire = cond;
            default:       fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/rbuf_tracker.sv
module rbuf_tracker #(
    parameter int ADDR_W = 31,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_mode,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              end_we,
    input  logic [ADDR_W-1:0] end_wdata,
    input  logic              mark_we,
    input  logic [ADDR_W-1:0] mark_wdata,
    input  logic              rdp_we,
    input  logic [ADDR_W:0]   rdp_wdata,
    input  logic              wrp_we,
    input  logic [ADDR_W:0]   wrp_wdata,
    input  logic              rearm,
    input  logic              adv_valid,
    input  logic [STEP_W-1:0] adv_bytes,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   fill_level,
    output logic              buf_empty,
    output logic              buf_full,
    output logic [ADDR_W-1:0] cur_offset,
    output logic              underflow,
    output logic              overflow,
    output logic              mark_evt
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int NPTR  = 2;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] end_q;
    logic [ADDR_W-1:0] mark_q;
    logic [PTR_W-1:0]  ptr_q   [NPTR];
    logic [PTR_W-1:0]  ptr_nxt [NPTR];
    logic [PTR_W-1:0]  step_v  [NPTR];
    logic [PTR_W-1:0]  sw_data [NPTR];
    logic [NPTR-1:0]   sw_we;

    logic [PTR_W-1:0]  buf_size;
    logic [PTR_W-1:0]  free_space;
    logic [PTR_W-1:0]  avail;
    logic [PTR_W-1:0]  adv_ext;
    logic [PTR_W-1:0]  grant;
    logic              mark_cond;
    logic              underflow_q;
    logic              overflow_q;

    assign rd_ptr = ptr_q[0];
    assign wr_ptr = ptr_q[1];
    assign sw_we  = {wrp_we, rdp_we};
    assign sw_data[0] = rdp_wdata;
    assign sw_data[1] = wrp_wdata;

    rbuf_level #(.ADDR_W(ADDR_W)) u_level (
        .base_a  (base_q),
        .end_a   (end_q),
        .rd_p    (ptr_q[0]),
        .wr_p    (ptr_q[1]),
        .size    (buf_size),
        .level   (fill_level),
        .free_sp (free_space),
        .empty   (buf_empty),
        .full    (buf_full)
    );

    always_comb begin
        avail   = capture_mode ? free_space : fill_level;
        adv_ext = PTR_W'(adv_bytes);
        if (!adv_valid) begin
            grant = '0;
        end else if (adv_ext > avail) begin
            grant = avail;
        end else begin
            grant = adv_ext;
        end
    end

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        localparam bit IS_WR = (i == 1);
        assign step_v[i] = (IS_WR == capture_mode) ? grant : '0;
        rbuf_step #(.ADDR_W(ADDR_W)) u_step (
            .ptr   (ptr_q[i]),
            .step  (step_v[i]),
            .end_a (end_q),
            .size  (buf_size),
            .nxt   (ptr_nxt[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            end_q       <= '0;
            mark_q      <= '0;
            underflow_q <= 1'b0;
            overflow_q  <= 1'b0;
            for (int i = 0; i < NPTR; i++) begin
                ptr_q[i] <= '0;
            end
        end else begin
            if (base_we) base_q <= base_wdata;
            if (end_we)  end_q  <= end_wdata;
            if (mark_we) mark_q <= mark_wdata;
            for (int i = 0; i < NPTR; i++) begin
                if (sw_we[i]) begin
                    ptr_q[i] <= sw_data[i];
                end else if (step_v[i] != '0) begin
                    ptr_q[i] <= ptr_nxt[i];
                end
            end
            underflow_q <= adv_valid && !capture_mode && buf_empty;
            overflow_q  <= adv_valid && capture_mode && buf_full;
        end
    end

    assign underflow = underflow_q;
    assign overflow  = overflow_q;

    assign cur_offset = (capture_mode ? ptr_q[1][ADDR_W-1:0] : ptr_q[0][ADDR_W-1:0]) - base_q;
    assign mark_cond  = capture_mode ? (fill_level > {1'b0, mark_q})
                                     : (free_space > {1'b0, mark_q});

    rbuf_mark_fsm u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .rearm (rearm),
        .cond  (mark_cond),
        .fire  (mark_evt)
    );

endmodule

// File: rtl/rbuf_tracker_chk.sv
module rbuf_tracker_chk #(
    parameter int ADDR_W = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic            capture_mode,
    input logic            adv_valid,
    input logic            wrp_we,
    input logic            rdp_we,
    input logic [ADDR_W:0] rd_ptr,
    input logic [ADDR_W:0] wr_ptr,
    input logic [ADDR_W:0] fill_level,
    input logic [ADDR_W:0] buf_size,
    input logic            buf_empty,
    input logic            buf_full,
    input logic            underflow,
    input logic            overflow,
    input logic            mark_evt
);
    // R2
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_empty && buf_full));

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= buf_size);

    // R10
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_evt |=> !mark_evt);

    // R6
    underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $past(adv_valid && !capture_mode && buf_empty));

    // R7
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(adv_valid && capture_mode && buf_full));

    // R4
    idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_mode && !wrp_we) |=> $stable(wr_ptr));

    // R4
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_mode && !rdp_we) |=> $stable(rd_ptr));

endmodule

bind rbuf_tracker rbuf_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_mode (capture_mode),
    .adv_valid    (adv_valid),
    .wrp_we       (wrp_we),
    .rdp_we       (rdp_we),
    .rd_ptr       (rd_ptr),
    .wr_ptr       (wr_ptr),
    .fill_level   (fill_level),
    .buf_size     (buf_size),
    .buf_empty    (buf_empty),
    .buf_full     (buf_full),
    .underflow    (underflow),
    .overflow     (overflow),
    .mark_evt     (mark_evt)
);

// File: tb/rbuf_tracker_test.sv
module rbuf_tracker_test;
    localparam int AW = 31;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_mode = 1'b0;
    logic          base_we = 1'b0, end_we = 1'b0, mark_we = 1'b0;
    logic [AW-1:0] base_wdata = '0, end_wdata = '0, mark_wdata = '0;
    logic          rdp_we = 1'b0, wrp_we = 1'b0;
    logic [AW:0]   rdp_wdata = '0, wrp_wdata = '0;
    logic          rearm = 1'b0;
    logic          adv_valid = 1'b0;
    logic [SW-1:0] adv_bytes = '0;
    logic [AW:0]   rd_ptr, wr_ptr, fill_level;
    logic          buf_empty, buf_full, underflow, overflow, mark_evt;
    logic [AW-1:0] cur_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rbuf_tracker #(.ADDR_W(AW), .STEP_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .capture_mode(capture_mode),
        .base_we(base_we), .base_wdata(base_wdata),
        .end_we(end_we), .end_wdata(end_wdata),
        .mark_we(mark_we), .mark_wdata(mark_wdata),
        .rdp_we(rdp_we), .rdp_wdata(rdp_wdata),
        .wrp_we(wrp_we), .wrp_wdata(wrp_wdata),
        .rearm(rearm), .adv_valid(adv_valid), .adv_bytes(adv_bytes),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .fill_level(fill_level),
        .buf_empty(buf_empty), .buf_full(buf_full), .cur_offset(cur_offset),
        .underflow(underflow), .overflow(overflow), .mark_evt(mark_evt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic advance(input int n);
        @(negedge clk);
        adv_valid = 1'b1;
        adv_bytes = SW'(n);
        @(negedge clk);
        adv_valid = 1'b0;
    endtask

    task automatic set_ptrs(input logic [AW:0] rd, input logic [AW:0] wr);
        @(negedge clk);
        rdp_we = 1'b1; rdp_wdata = rd;
        wrp_we = 1'b1; wrp_wdata = wr;
        @(negedge clk);
        rdp_we = 1'b0; wrp_we = 1'b0;
    endtask

    task automatic pulse_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 wr_ptr", wr_ptr, 0);
        chk("R1 empty", buf_empty, 1);
        chk("R1 full", buf_full, 0);
        chk("R1 mark_evt quiet", mark_evt, 0);
        chk("R1 underflow", underflow, 0);
    endtask

    task automatic t_config();
        @(negedge clk);
        base_we = 1'b1; base_wdata = AW'(32'h1000);
        end_we  = 1'b1; end_wdata  = AW'(32'h13FF);
        mark_we = 1'b1; mark_wdata = AW'(32'h100);
        @(negedge clk);
        base_we = 1'b0; end_we = 1'b0; mark_we = 1'b0;
    endtask

    task automatic t_playback_mark();
        capture_mode = 1'b0;
        set_ptrs(32'h0000_1000, 32'h8000_1000);
        chk("R2 full", buf_full, 1);
        chk("R2 not empty", buf_empty, 0);
        chk("R3 full level", fill_level, 32'h400);
        chk("R12 offset zero", cur_offset, 0);
        pulse_rearm();
        chk("R8 no free space", mark_evt, 0);
        advance(32'h100);
        chk("R4 rd moved", rd_ptr, 32'h0000_1100);
        chk("R12 offset", cur_offset, 32'h100);
        chk("R8 free equal mark", mark_evt, 0);
        advance(32'h10);
        chk("R8 free above mark", mark_evt, 1);
        idle();
        chk("R10 single cycle", mark_evt, 0);
        advance(32'h10);
        chk("R10 stays quiet", mark_evt, 0);
        pulse_rearm();
        chk("R10 refire after rearm", mark_evt, 1);
        idle();
        chk("R10 quiet again", mark_evt, 0);
    endtask

    task automatic t_wrap();
        set_ptrs(32'h0000_13F0, 32'h8000_1010);
        chk("R3 level across lap", fill_level, 32'h20);
        advance(32'h20);
        chk("R4 wrap to base", rd_ptr, 32'h8000_1010);
        chk("R2 empty", buf_empty, 1);
    endtask

    task automatic t_underflow_clamp();
        advance(32'h40);
        chk("R6 underflow flag", underflow, 1);
        chk("R6 rd unchanged", rd_ptr, 32'h8000_1010);
        idle();
        chk("R6 flag one cycle", underflow, 0);
        @(negedge clk);
        wrp_we = 1'b1; wrp_wdata = 32'h8000_1030;
        @(negedge clk);
        wrp_we = 1'b0;
        chk("R3 level", fill_level, 32'h20);
        advance(32'h100);
        chk("R5 clamped rd", rd_ptr, 32'h8000_1030);
        chk("R5 no underflow", underflow, 0);
        chk("R4 wr untouched", wr_ptr, 32'h8000_1030);
    endtask

    task automatic t_capture();
        capture_mode = 1'b1;
        set_ptrs(32'h0000_1000, 32'h0000_1000);
        pulse_rearm();
        chk("R9 empty no event", mark_evt, 0);
        advance(32'h100);
        chk("R9 level equal mark", mark_evt, 0);
        advance(32'h200);
        chk("R9 level above mark", mark_evt, 1);
        chk("R12 capture offset", cur_offset, 32'h300);
        chk("R4 rd untouched", rd_ptr, 32'h0000_1000);
        advance(32'h100);
        chk("R4 capture wrap", wr_ptr, 32'h8000_1000);
        chk("R2 capture full", buf_full, 1);
        advance(32'h10);
        chk("R7 overflow flag", overflow, 1);
        chk("R7 wr unchanged", wr_ptr, 32'h8000_1000);
        idle();
        chk("R7 flag one cycle", overflow, 0);
    endtask

    task automatic t_sw_priority();
        set_ptrs(32'h0000_1000, 32'h0000_1000);
        @(negedge clk);
        wrp_we = 1'b1; wrp_wdata = 32'h0000_1200;
        adv_valid = 1'b1; adv_bytes = 16'h50;
        @(negedge clk);
        wrp_we = 1'b0; adv_valid = 1'b0;
        chk("R11 write wins", wr_ptr, 32'h0000_1200);
        chk("R11 level", fill_level, 32'h200);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_playback_mark();
        t_wrap();
        t_underflow_clamp();
        t_capture();
        t_sw_priority();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule